// File: doc/BRIEF.md
# Counter Command Engine with Busy/Status Handshake

This block gives software a register window for launching long-running commands on a bank of performance counters inside an address-translation unit. Software may first store a second operand. It then writes a 64-bit command word that holds an 8-bit opcode in its low byte and a counter index from bit 16 upward. The engine raises a busy flag, decodes the command, runs it for a configurable number of cycles, applies it to the counter bank, and then drops the flag and reports a completion code. A 256-bit read-only bitmap, read as four 64-bit words, tells software which opcodes the engine accepts.

The sequencer has three states. `S_IDLE` waits for a command; the transition *accept* (a command write while idle) leads to `S_DECODE`. From `S_DECODE` the transition *reject* (opcode not in the bitmap, or index out of range) returns to `S_IDLE` with an error code, and the transition *launch* enters `S_EXEC`. `S_EXEC` counts down, and the transition *complete* applies the action and returns to `S_IDLE` with the success code. A command written while the engine is not idle is dropped.

Top module: `ecmd_engine`

## Requirements
- R1: After reset the response register reads 0, every counter enable and freeze bit is 0, and the command register reads 0.
- R2: A command write to offset 0x400 while idle sets response bit 0 (busy) from the next cycle. For an accepted command, busy stays high for EXEC_CYCLES+1 cycles and then clears, with response bits [7:1] equal to 0 (success).
- R3: On success, opcode 0xF0 sets the enable bit of the counter named by command bits [63:16], 0xF1 clears it, 0xF4 sets its freeze bit and 0xF5 clears it. No other counter changes.
- R4: The capability words at 0x430, 0x438, 0x440 and 0x448 carry one bit per opcode (word n bit b is opcode 64n+b). Word 3 has bits 48, 49, 52 and 53 set, and every other bit of all four words is 0.
- R5: An opcode whose capability bit is 0 keeps busy high for exactly one cycle, completes with status 1, and changes no counter.
- R6: A supported opcode whose index is NUM_CTR or more keeps busy high for exactly one cycle, completes with status 2, and changes no counter.
- R7: A command write while busy is dropped. The running command completes with its own status, and the dropped command has no effect on any counter.
- R8: Offset 0x408 stores a 64-bit extra operand that reads back as written. Its value has no effect on the status or on the counters.
- R9: Writes to the response register and to the capability words leave their read values unchanged.
- R10: Offset 0x400 reads back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (12) | Byte offset of the register accessed |
| reg_wdata | input | DATA_W (64) | Write data |
| reg_rdata | output | DATA_W (64) | Read data for reg_addr, combinational |
| ctr_enable | output | NUM_CTR (8) | Per-counter enable state |
| ctr_freeze | output | NUM_CTR (8) | Per-counter freeze state |

## Verification
The hardest case to reach is a second command that arrives during the busy window of the first. It must be dropped with no trace: it must neither restart the sequencer nor overwrite the stored command or the pending status. The bench launches a valid enable command and then, within the same busy window, writes a conflicting disable for the same counter and a write to the response register. After busy clears, it checks that the counter shows only the first command's effect and that the command register still holds the first word. Busy-window lengths are counted cycle by cycle, so a one-cycle reject path can be told apart from the full execution path.

// File: rtl/ecmd_pkg.sv
package ecmd_pkg;

    // register offsets (byte addresses inside the window)
    localparam logic [11:0] OFS_CMD  = 12'h400;
    localparam logic [11:0] OFS_XOP  = 12'h408;
    localparam logic [11:0] OFS_RSP  = 12'h410;
    localparam logic [11:0] OFS_CAP0 = 12'h430;
    localparam int unsigned CAP_STEP = 8;

    // counter-bank opcodes
    localparam logic [7:0] OP_CTR_ON      = 8'hF0;
    localparam logic [7:0] OP_CTR_OFF     = 8'hF1;
    localparam logic [7:0] OP_CTR_HOLD    = 8'hF4;
    localparam logic [7:0] OP_CTR_RELEASE = 8'hF5;

    // completion codes, response bits [7:1]
    localparam logic [6:0] ST_OK          = 7'd0;
    localparam logic [6:0] ST_UNSUPPORTED = 7'd1;
    localparam logic [6:0] ST_BAD_OPERAND = 7'd2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DECODE = 2'd1,
        S_EXEC   = 2'd2
    } seq_state_e;

    function automatic logic op_supported(input logic [7:0] op);
        return (op == OP_CTR_ON) || (op == OP_CTR_OFF) ||
               (op == OP_CTR_HOLD) || (op == OP_CTR_RELEASE);
    endfunction

endpackage

// File: rtl/ecmd_capmap.sv
module ecmd_capmap
    import ecmd_pkg::*;
#(
    parameter int unsigned NUM_OPS = 256
) (
    output logic [NUM_OPS-1:0] cap_bits
);
    // one capability bit per opcode, derived from the supported set
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_cap
        assign cap_bits[op] = op_supported(8'(op));
    end
endmodule

// File: rtl/ecmd_ctr_bank.sv
module ecmd_ctr_bank
    import ecmd_pkg::*;
#(
    parameter int unsigned NUM_CTR = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  logic [7:0]         apply_op,
    input  logic [IDX_W-1:0]   apply_idx,
    output logic [NUM_CTR-1:0] ctr_enable,
    output logic [NUM_CTR-1:0] ctr_freeze
);
    for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
        logic hit;
        assign hit = apply && (apply_idx == IDX_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctr_enable[c] <= 1'b0;
                ctr_freeze[c] <= 1'b0;
            end else if (hit) begin
                unique case (apply_op)
                    OP_CTR_ON:      ctr_enable[c] <= 1'b1;
                    OP_CTR_OFF:     ctr_enable[c] <= 1'b0;
                    OP_CTR_HOLD:    ctr_freeze[c] <= 1'b1;
                    OP_CTR_RELEASE: ctr_freeze[c] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ecmd_seq.sv
module ecmd_seq
    import ecmd_pkg::*;
#(
    parameter int unsigned NUM_OPS     = 256,
    parameter int unsigned NUM_CTR     = 8,
    parameter int unsigned EXEC_CYCLES = 4,
    parameter int unsigned OPND_W      = 48,
    parameter int unsigned IDX_W       = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [7:0]         go_op,
    input  logic [OPND_W-1:0]  go_opnd,
    input  logic [NUM_OPS-1:0] cap_bits,
    output logic               busy,
    output logic [6:0]         status,
    output logic               apply,
    output logic [7:0]         apply_op,
    output logic [IDX_W-1:0]   apply_idx
);
    localparam int unsigned CNT_W = $clog2(EXEC_CYCLES + 1);

    seq_state_e        state_q, state_d;
    logic [7:0]        op_q;
    logic [OPND_W-1:0] opnd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [6:0]        status_q;

    logic cap_hit, opnd_ok, last;
    assign cap_hit = cap_bits[op_q];
    assign opnd_ok = opnd_q < OPND_W'(NUM_CTR);
    assign last    = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, reject, launch, complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go) state_d = S_DECODE;
            S_DECODE: state_d = (cap_hit && opnd_ok) ? S_EXEC : S_IDLE;
            S_EXEC:   if (last) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            opnd_q   <= '0;
            cnt_q    <= '0;
            status_q <= ST_OK;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (go) begin
                        op_q   <= go_op;
                        opnd_q <= go_opnd;
                    end
                end
                S_DECODE: begin
                    cnt_q <= CNT_W'(EXEC_CYCLES - 1);
                    if (!cap_hit)      status_q <= ST_UNSUPPORTED;
                    else if (!opnd_ok) status_q <= ST_BAD_OPERAND;
                end
                S_EXEC: begin
                    if (!last) cnt_q    <= cnt_q - 1'b1;
                    else       status_q <= ST_OK;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign status    = status_q;
    assign apply     = (state_q == S_EXEC) && last;
    assign apply_op  = op_q;
    assign apply_idx = opnd_q[IDX_W-1:0];
endmodule

// File: rtl/ecmd_engine.sv
module ecmd_engine
    import ecmd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned NUM_CTR     = 8,
    parameter int unsigned EXEC_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_CTR-1:0] ctr_enable,
    output logic [NUM_CTR-1:0] ctr_freeze
);
    localparam int unsigned NUM_OPS  = 256;
    localparam int unsigned CAP_REGS = NUM_OPS / DATA_W;
    localparam int unsigned OPC_W    = 8;
    localparam int unsigned OPND_LSB = 16;
    localparam int unsigned OPND_W   = DATA_W - OPND_LSB;
    localparam int unsigned IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    logic [DATA_W-1:0]  cmd_q, xop_q, rsp_word;
    logic [NUM_OPS-1:0] cap_bits;
    logic               seq_busy, seq_go, seq_apply;
    logic [6:0]         seq_status;
    logic [7:0]         seq_apply_op;
    logic [IDX_W-1:0]   seq_apply_idx;
    logic               wr_cmd, wr_xop;

    assign wr_cmd = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
    assign wr_xop = reg_wr && (reg_addr == ADDR_W'(OFS_XOP));
    assign seq_go = wr_cmd && !seq_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            xop_q <= '0;
        end else begin
            if (seq_go) cmd_q <= reg_wdata;
            if (wr_xop) xop_q <= reg_wdata;
        end
    end

    assign rsp_word = {{(DATA_W-8){1'b0}}, seq_status, seq_busy};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CMD)) reg_rdata = cmd_q;
        if (reg_addr == ADDR_W'(OFS_XOP)) reg_rdata = xop_q;
        if (reg_addr == ADDR_W'(OFS_RSP)) reg_rdata = rsp_word;
        for (int i = 0; i < CAP_REGS; i++) begin
            if (reg_addr == ADDR_W'(OFS_CAP0) + ADDR_W'(CAP_STEP * i))
                reg_rdata = cap_bits[i*DATA_W +: DATA_W];
        end
    end

    ecmd_capmap #(.NUM_OPS(NUM_OPS)) u_cap (
        .cap_bits (cap_bits)
    );

    ecmd_seq #(
        .NUM_OPS     (NUM_OPS),
        .NUM_CTR     (NUM_CTR),
        .EXEC_CYCLES (EXEC_CYCLES),
        .OPND_W      (OPND_W),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (seq_go),
        .go_op     (reg_wdata[OPC_W-1:0]),
        .go_opnd   (reg_wdata[DATA_W-1:OPND_LSB]),
        .cap_bits  (cap_bits),
        .busy      (seq_busy),
        .status    (seq_status),
        .apply     (seq_apply),
        .apply_op  (seq_apply_op),
        .apply_idx (seq_apply_idx)
    );

    ecmd_ctr_bank #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply      (seq_apply),
        .apply_op   (seq_apply_op),
        .apply_idx  (seq_apply_idx),
        .ctr_enable (ctr_enable),
        .ctr_freeze (ctr_freeze)
    );
endmodule

// File: rtl/ecmd_chk.sv
module ecmd_chk
    import ecmd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_CTR     = 8,
    parameter int unsigned EXEC_CYCLES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               busy,
    input logic [6:0]         status,
    input logic [NUM_CTR-1:0] ctr_enable,
    input logic [NUM_CTR-1:0] ctr_freeze
);
    logic [15:0] busy_run;
    logic        cmd_wr;
    assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);

    a_r2_busy_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run <= 16'(EXEC_CYCLES)));

    a_r2_success_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && status == ST_OK) |-> (busy_run == 16'(EXEC_CYCLES + 1)));

    a_r5_reject_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && status != ST_OK) |-> (busy_run == 16'd1));

    a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (status <= ST_BAD_OPERAND));

    a_r7_counters_move_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctr_enable != $past(ctr_enable)) || (ctr_freeze != $past(ctr_freeze)))
            |-> ($fell(busy) && status == ST_OK));

    a_r9_idle_response_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_wr) |=> (!busy && $stable(status)));
endmodule

bind ecmd_engine ecmd_chk #(
    .ADDR_W      (ADDR_W),
    .NUM_CTR     (NUM_CTR),
    .EXEC_CYCLES (EXEC_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .busy       (seq_busy),
    .status     (seq_status),
    .ctr_enable (ctr_enable),
    .ctr_freeze (ctr_freeze)
);

// File: tb/sim_ecmd_engine.sv
module sim_ecmd_engine;
    localparam int NCTR = 8;
    localparam int EXEC = 4;
    localparam logic [11:0] A_CMD  = 12'h400;
    localparam logic [11:0] A_XOP  = 12'h408;
    localparam logic [11:0] A_RSP  = 12'h410;
    localparam logic [11:0] A_CAP0 = 12'h430;

    localparam int NV = 10;
    localparam logic [63:0] V_CMD [NV] = '{
        64'h0000_0000_0002_00F0,  // enable ctr 2
        64'h0000_0000_0002_00F4,  // freeze ctr 2
        64'h0000_0000_0007_00F0,  // enable ctr 7
        64'h0000_0000_0002_00F5,  // unfreeze ctr 2
        64'h0000_0000_0002_00F1,  // disable ctr 2
        64'h0000_0000_0001_0037,  // unsupported opcode
        64'h0000_0000_0000_00F2,  // unsupported, inside the gap
        64'h0000_0000_0008_00F0,  // index just past range
        64'hFFFF_FFFF_FFFF_00F4,  // huge index
        64'h0000_0000_0007_00F1   // disable ctr 7
    };
    localparam logic [6:0] V_ST [NV] = '{
        7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd1, 7'd1, 7'd2, 7'd2, 7'd0
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [11:0]     reg_addr = A_RSP;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic [NCTR-1:0] ctr_enable, ctr_freeze;

    int errors = 0;
    int checks = 0;
    logic [NCTR-1:0] m_en = '0;
    logic [NCTR-1:0] m_frz = '0;

    always #10 clk = ~clk;

    ecmd_engine #(.NUM_CTR(NCTR), .EXEC_CYCLES(EXEC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctr_enable(ctr_enable), .ctr_freeze(ctr_freeze)
    );

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_RSP;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [63:0] r;
        n = 0;
        for (int k = 0; k < 64; k++) begin
            rd(A_RSP, r);
            if (r[0] !== 1'b1) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic model(input logic [63:0] c);
        int idx;
        idx = int'(c[18:16]);
        case (c[7:0])
            8'hF0: m_en[idx]  = 1'b1;
            8'hF1: m_en[idx]  = 1'b0;
            8'hF4: m_frz[idx] = 1'b1;
            8'hF5: m_frz[idx] = 1'b0;
            default: ;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_RSP, r); chk("R1 response after reset", r, 64'd0);
        rd(A_CMD, r); chk("R1 command after reset", r, 64'd0);
        chk("R1 enables after reset", 64'(ctr_enable), 64'd0);
        chk("R1 freezes after reset", 64'(ctr_freeze), 64'd0);

        // R4 capability words
        for (int i = 0; i < 4; i++) begin
            rd(A_CAP0 + 12'(8 * i), r);
            chk($sformatf("R4 capability word %0d", i), r,
                (i == 3) ? ((64'd1 << 48) | (64'd1 << 49) | (64'd1 << 52) | (64'd1 << 53)) : 64'd0);
        end

        // vector table: R2 R3 R5 R6 R8 R10
        for (int v = 0; v < NV; v++) begin
            wr(A_XOP, ~V_CMD[v]);
            rd(A_XOP, r); chk($sformatf("R8 extra operand readback v%0d", v), r, ~V_CMD[v]);
            wr(A_CMD, V_CMD[v]);
            wait_idle(n);
            chk($sformatf("R2/R5/R6 busy cycles v%0d", v), 64'(n),
                (V_ST[v] == 7'd0) ? 64'(EXEC + 1) : 64'd1);
            rd(A_RSP, r);
            chk($sformatf("R2/R5/R6 status v%0d", v), r, {56'd0, V_ST[v], 1'b0});
            rd(A_CMD, r); chk($sformatf("R10 command readback v%0d", v), r, V_CMD[v]);
            if (V_ST[v] == 7'd0) model(V_CMD[v]);
            chk($sformatf("R3 enables v%0d", v), 64'(ctr_enable), 64'(m_en));
            chk($sformatf("R3 freezes v%0d", v), 64'(ctr_freeze), 64'(m_frz));
        end

        // R9 writes to response and capability are ignored
        wr(A_RSP, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_RSP, r); chk("R9 response after write", r, 64'd0);
        wr(A_CAP0 + 12'd24, 64'd0);
        rd(A_CAP0 + 12'd24, r);
        chk("R9 capability after write", r,
            (64'd1 << 48) | (64'd1 << 49) | (64'd1 << 52) | (64'd1 << 53));

        // R7 overlapping command is dropped
        wr(A_CMD, 64'h0000_0000_0003_00F0);
        wr(A_CMD, 64'h0000_0000_0003_00F1);
        wr(A_RSP, 64'h0000_0000_0000_00FE);
        wait_idle(n);
        m_en[3] = 1'b1;
        rd(A_RSP, r); chk("R7 status after overlap", r, 64'd0);
        rd(A_CMD, r); chk("R7 command kept after overlap", r, 64'h0000_0000_0003_00F0);
        chk("R7 enables after overlap", 64'(ctr_enable), 64'(m_en));
        repeat (8) @(negedge clk);
        chk("R7 dropped command never ran", 64'(ctr_enable), 64'(m_en));

        // R5 error status replaced by later success
        wr(A_CMD, 64'h0000_0000_0000_0000);
        wait_idle(n);
        rd(A_RSP, r); chk("R5 opcode 0 unsupported", r, 64'h2);
        wr(A_CMD, 64'h0000_0000_0000_00F4);
        wait_idle(n);
        m_frz[0] = 1'b1;
        rd(A_RSP, r); chk("R2 success after error", r, 64'd0);
        chk("R3 freeze ctr 0", 64'(ctr_freeze), 64'(m_frz));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule